// File: doc/BRIEF.md
# Split-Address Region Permission Checker

This block watches one address window on a bus and decides, for every access that falls inside it, whether the access is allowed. A programmable split address cuts the window in two. Each half has its own read, write and fetch permission bits. The block does not stall or answer the access. It raises a combinational deny flag in the same cycle, records the first denied access, and drives an interrupt line that software can enable and clear.

Software reaches the block through a small register port with four registers: configuration, control, fault status and lock. A configuration write whose split address lies outside the window, or is not 4-byte aligned, is rejected as a whole. Once the lock bit is set, the configuration and the interrupt enable are frozen until the next reset. Clearing the interrupt still works while locked.

Top module: `split_region_guard`

## Requirements
- R1: After reset the configuration reads back split = window base with all six permission bits set, and control, fault status and lock all read 0; irq is 0.
- R2: The configuration register (select 0) holds the split address in bits [31:16] and the permissions in bits [5:0]: bit0 low read, bit1 low write, bit2 low fetch, bit3 high read, bit4 high write, bit5 high fetch. An accepted write reads back unchanged and all other bits read 0.
- R3: A configuration write whose split address is below the window base (0x4000) or above the window top (0x5FFF) is rejected, and split and permissions keep their old values.
- R4: A configuration write whose split address has bit 1 or bit 0 set is rejected.
- R5: An access inside the window at an address at or above the split uses the high permissions; one below the split uses the low permissions. acc_kind encodes 0 read, 1 write, 2 fetch, 3 none. acc_deny is high in the same cycle when acc_valid is set and the bit for the part and kind is 0. Kind 3 is never denied.
- R6: Accesses outside the window are never denied and change neither the pending flag nor the fault status.
- R7: The first denied access sets the pending flag at the next clock edge. Fault status (select 2) then holds the address in bits [15:0], bit16 = 1 for a write, bit17 = 1 for a fetch. Later denials do not overwrite it while the flag is pending.
- R8: The clear bit (control bit1) is a level. In every cycle it reads 1, the pending flag drops at the next edge and a denial in that cycle is not recorded.
- R9: Control (select 1) reads bit0 enable, bit1 clear, bit2 pending. irq is high exactly when enable and pending are both 1.
- R10: Writing select 3 with bit0 = 1 sets the lock bit. Writing 0 has no effect, and only reset clears the lock.
- R11: While locked, configuration writes and changes to the enable bit are ignored, but the clear bit is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 control, 2 fault, 3 lock |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | A bus access is presented this cycle |
| acc_addr | input | 16 | Access address |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 none |
| acc_deny | output | 1 | Access violates the permissions (combinational) |
| irq | output | 1 | Interrupt: pending and enabled |

## Verification
The interesting collision is between a new denial and the interrupt clear. A denied access is driven in the very cycle the clear bit goes high, and again while it is held high. The first must be captured and then dropped one edge later. The second must leave neither the pending flag nor the fault status changed. A second collision pairs a configuration or enable write with the lock, in the cycles before and after the lock takes effect. The cycle-level reference model in the bench judges both by its own ordering of capture, clear and register write.

// File: rtl/srg_pkg.sv
package srg_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    // bit 0 is lo_r; order matters for the register layout
    typedef struct packed {
        logic hi_x;
        logic hi_w;
        logic hi_r;
        logic lo_x;
        logic lo_w;
        logic lo_r;
    } perm_t;

    localparam int PERM_W    = 6;
    localparam int PART_W    = 3;

    localparam logic [1:0] SEL_CFG   = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_FAULT = 2'd2;
    localparam logic [1:0] SEL_LOCK  = 2'd3;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_CLR  = 1;
    localparam int CTRL_PEND = 2;

endpackage

// File: rtl/srg_cfg_regs.sv
module srg_cfg_regs
    import srg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 32,
    parameter int              ALIGN_W  = 2,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_TOP  = 16'h5FFF,
    parameter logic [PERM_W-1:0] RST_PERM = 6'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] split_o,
    output perm_t             perm_o,
    output logic              en_o,
    output logic              clr_o,
    output logic              lock_o
);

    localparam int SPLIT_LSB = DATA_W - ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] split;
        perm_t             perm;
        logic              en;
        logic              clr;
        logic              lock;
    } cfg_t;

    cfg_t              s_d, s_q;
    logic [ADDR_W-1:0] wr_split;
    logic              split_in_win;
    logic              split_aligned;
    logic              split_ok;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[SPLIT_LSB-1:PERM_W];

    always_comb begin
        wr_split      = reg_wdata[DATA_W-1:SPLIT_LSB];
        split_in_win  = (wr_split >= WIN_BASE) && (wr_split <= WIN_TOP);
        split_aligned = (wr_split[ALIGN_W-1:0] == '0);
        split_ok      = split_in_win && split_aligned;

        s_d = s_q;
        if (reg_wr) begin
            case (reg_sel)
                SEL_CFG: begin
                    // rejected writes leave split and permissions as they were
                    if (!s_q.lock && split_ok) begin
                        s_d.split = wr_split;
                        s_d.perm  = perm_t'(reg_wdata[PERM_W-1:0]);
                    end
                end
                SEL_CTRL: begin
                    if (!s_q.lock) begin
                        s_d.en = reg_wdata[CTRL_EN];
                    end
                    s_d.clr = reg_wdata[CTRL_CLR];
                end
                SEL_LOCK: begin
                    if (reg_wdata[0]) begin
                        s_d.lock = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.split <= WIN_BASE;
            s_q.perm  <= perm_t'(RST_PERM);
            s_q.en    <= 1'b0;
            s_q.clr   <= 1'b0;
            s_q.lock  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign split_o = s_q.split;
    assign perm_o  = s_q.perm;
    assign en_o    = s_q.en;
    assign clr_o   = s_q.clr;
    assign lock_o  = s_q.lock;

endmodule

// File: rtl/srg_perm_check.sv
module srg_perm_check
    import srg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_TOP  = 16'h5FFF
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] split_i,
    input  perm_t             perm_i,
    output logic              in_win_o,
    output logic              deny_o
);

    logic                    hi_part;
    logic [PERM_W-1:0]       perm_vec;
    logic [PART_W-1:0]       part_perm;
    logic                    grant;

    assign perm_vec = perm_i;
    assign hi_part  = (acc_addr >= split_i);

    // pick read/write/fetch bits of the half the address falls in
    for (genvar k = 0; k < PART_W; k++) begin : g_part
        assign part_perm[k] = hi_part ? perm_vec[PART_W + k] : perm_vec[k];
    end

    always_comb begin
        in_win_o = (acc_addr >= WIN_BASE) && (acc_addr <= WIN_TOP);
        case (acc_kind)
            ACC_READ:  grant = part_perm[0];
            ACC_WRITE: grant = part_perm[1];
            ACC_FETCH: grant = part_perm[2];
            default:   grant = 1'b1;
        endcase
        deny_o = acc_valid && in_win_o && !grant;
    end

endmodule

// File: rtl/srg_fault_capture.sv
module srg_fault_capture
    import srg_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny_i,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              clr_i,
    output logic              pend_o,
    output logic [ADDR_W-1:0] f_addr_o,
    output logic              f_wr_o,
    output logic              f_fx_o
);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              fx;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            // clear level wins over a denial in the same cycle
            s_d.pend = 1'b0;
        end else if (!s_q.pend && deny_i) begin
            s_d.pend = 1'b1;
            s_d.addr = acc_addr;
            s_d.wr   = (acc_kind == ACC_WRITE);
            s_d.fx   = (acc_kind == ACC_FETCH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o   = s_q.pend;
    assign f_addr_o = s_q.addr;
    assign f_wr_o   = s_q.wr;
    assign f_fx_o   = s_q.fx;

endmodule

// File: rtl/split_region_guard.sv
module split_region_guard
    import srg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 32,
    parameter int                ALIGN_W  = 2,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_TOP  = 16'h5FFF,
    parameter logic [PERM_W-1:0] RST_PERM = 6'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    output logic              acc_deny,
    output logic              irq
);

    localparam int SPLIT_LSB = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] cfg_split;
    perm_t             cfg_perm;
    logic              cfg_en;
    logic              cfg_clr;
    logic              cfg_lock;
    logic              chk_in_win;
    logic              chk_deny;
    logic              flt_pend;
    logic [ADDR_W-1:0] flt_addr;
    logic              flt_wr;
    logic              flt_fx;

    srg_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ALIGN_W  (ALIGN_W),
        .WIN_BASE (WIN_BASE),
        .WIN_TOP  (WIN_TOP),
        .RST_PERM (RST_PERM)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .split_o   (cfg_split),
        .perm_o    (cfg_perm),
        .en_o      (cfg_en),
        .clr_o     (cfg_clr),
        .lock_o    (cfg_lock)
    );

    srg_perm_check #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_TOP  (WIN_TOP)
    ) u_check (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_kind  (acc_kind),
        .split_i   (cfg_split),
        .perm_i    (cfg_perm),
        .in_win_o  (chk_in_win),
        .deny_o    (chk_deny)
    );

    srg_fault_capture #(
        .ADDR_W (ADDR_W)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .deny_i   (chk_deny),
        .acc_addr (acc_addr),
        .acc_kind (acc_kind),
        .clr_i    (cfg_clr),
        .pend_o   (flt_pend),
        .f_addr_o (flt_addr),
        .f_wr_o   (flt_wr),
        .f_fx_o   (flt_fx)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CFG: begin
                reg_rdata[DATA_W-1:SPLIT_LSB] = cfg_split;
                reg_rdata[PERM_W-1:0]         = cfg_perm;
            end
            SEL_CTRL: begin
                reg_rdata[CTRL_EN]   = cfg_en;
                reg_rdata[CTRL_CLR]  = cfg_clr;
                reg_rdata[CTRL_PEND] = flt_pend;
            end
            SEL_FAULT: begin
                reg_rdata[ADDR_W-1:0] = flt_addr;
                reg_rdata[ADDR_W]     = flt_wr;
                reg_rdata[ADDR_W+1]   = flt_fx;
            end
            default: begin
                reg_rdata[0] = cfg_lock;
            end
        endcase
    end

    assign acc_deny = chk_deny;
    assign irq      = flt_pend && cfg_en;

endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_TOP  = 16'h5FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_deny,
    input logic              irq,
    input logic [ADDR_W-1:0] split,
    input logic [5:0]        perm,
    input logic              en,
    input logic              clr,
    input logic              lock,
    input logic              pend,
    input logic [ADDR_W-1:0] f_addr,
    input logic              f_wr,
    input logic              f_fx
);

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(split) && $stable(perm) && $stable(en)));

    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend);

    a_r7_first_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !clr && acc_deny) |=> pend);

    a_r7_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> (pend && $stable(f_addr) && $stable(f_wr) && $stable(f_fx)));

    a_r6_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ((acc_addr < WIN_BASE) || (acc_addr > WIN_TOP))) |-> !acc_deny);

    a_r3_split_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (split >= WIN_BASE) && (split <= WIN_TOP));

    a_r4_split_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        split[1:0] == 2'b00);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !pend) |-> !irq);

endmodule

bind split_region_guard srg_checker #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_TOP  (WIN_TOP)
) u_srg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_deny  (acc_deny),
    .irq       (irq),
    .split     (cfg_split),
    .perm      (cfg_perm),
    .en        (cfg_en),
    .clr       (cfg_clr),
    .lock      (cfg_lock),
    .pend      (flt_pend),
    .f_addr    (flt_addr),
    .f_wr      (flt_wr),
    .f_fx      (flt_fx)
);

// File: tb/split_region_guard_tb.sv
module split_region_guard_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_kind = 2'd3;
    logic        acc_deny;
    logic        irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // behavioural reference state
    logic [15:0] m_split;
    logic [5:0]  m_perm;
    bit          m_en, m_clr, m_pend, m_lock, m_fw, m_ffx;
    logic [15:0] m_faddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_region_guard u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_kind  (acc_kind),
        .acc_deny  (acc_deny),
        .irq       (irq)
    );

    function automatic bit mdl_deny();
        int idx;
        if (!acc_valid || acc_kind == 2'd3) return 1'b0;
        if (acc_addr < 16'h4000 || acc_addr > 16'h5FFF) return 1'b0;
        idx = int'(acc_kind) + ((acc_addr >= m_split) ? 3 : 0);
        return !m_perm[idx];
    endfunction

    function automatic logic [31:0] mdl_rd(input logic [1:0] sel);
        case (sel)
            2'd0:    return {m_split, 10'd0, m_perm};
            2'd1:    return {29'd0, m_pend, m_clr, m_en};
            2'd2:    return {14'd0, m_ffx, m_fw, m_faddr};
            default: return {31'd0, m_lock};
        endcase
    endfunction

    function automatic string sel_tag(input logic [1:0] sel);
        case (sel)
            2'd0:    return "R2 config readback";
            2'd1:    return "R9 control readback";
            2'd2:    return "R7 fault readback";
            default: return "R10 lock readback";
        endcase
    endfunction

    always @(posedge clk) begin
        bit          dn;
        logic [15:0] ws;
        if (!rst_n) begin
            m_split = 16'h4000; m_perm = 6'h3F;
            m_en = 0; m_clr = 0; m_pend = 0; m_lock = 0;
            m_faddr = '0; m_fw = 0; m_ffx = 0;
        end else begin
            dn = mdl_deny();
            if (m_clr) m_pend = 0;
            else if (!m_pend && dn) begin
                m_pend = 1; m_faddr = acc_addr;
                m_fw = (acc_kind == 2'd1); m_ffx = (acc_kind == 2'd2);
            end
            if (reg_wr) begin
                ws = reg_wdata[31:16];
                case (reg_sel)
                    2'd0: if (!m_lock && ws >= 16'h4000 && ws <= 16'h5FFF && ws[1:0] == 2'b00) begin
                        m_split = ws; m_perm = reg_wdata[5:0];
                    end
                    2'd1: begin
                        if (!m_lock) m_en = reg_wdata[0];
                        m_clr = reg_wdata[1];
                    end
                    2'd2: ;
                    default: if (reg_wdata[0]) m_lock = 1;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 deny vs model", 32'(acc_deny), 32'(mdl_deny()));
            chk("R9 irq vs model", 32'(irq), 32'(m_en && m_pend));
            chk(sel_tag(reg_sel), reg_rdata, mdl_rd(reg_sel));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        step();
    endtask

    task automatic access(input logic [15:0] a, input logic [1:0] k, input bit exp, input string tag);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k;
        @(negedge clk);
        chk(tag, 32'(acc_deny), 32'(exp));
        step();
        acc_valid = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        expect_reg(2'd0, 32'h4000_003F, "R1 config after reset");
        expect_reg(2'd1, 32'h0, "R1 control after reset");
        expect_reg(2'd2, 32'h0, "R1 fault after reset");
        expect_reg(2'd3, 32'h0, "R1 lock after reset");
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R2 layout: low r/w, high r only
        wr(2'd0, 32'h4800_000B);
        expect_reg(2'd0, 32'h4800_000B, "R2 config accepted");
        wr(2'd1, 32'h1);
        access(16'h47FC, 2'd1, 1'b0, "R5 low write allowed");
        access(16'h4800, 2'd1, 1'b1, "R5 split address is high part");
        expect_reg(2'd1, 32'h5, "R7 pending set");
        chk("R9 irq with pending and enable", 32'(irq), 32'h1);
        expect_reg(2'd2, 32'h0001_4800, "R7 fault write capture");
        access(16'h4804, 2'd2, 1'b1, "R5 high fetch denied");
        access(16'h4000, 2'd0, 1'b0, "R5 low read allowed");
        expect_reg(2'd2, 32'h0001_4800, "R7 first fault kept");

        // R8 clear wins over a denial while clear is high
        wr(2'd1, 32'h3);
        access(16'h4010, 2'd2, 1'b1, "R8 denial during clear");
        expect_reg(2'd1, 32'h3, "R8 pending dropped");
        expect_reg(2'd2, 32'h0001_4800, "R8 denial not recorded");
        wr(2'd1, 32'h1);

        // R6 outside window
        access(16'h6000, 2'd1, 1'b0, "R6 above window");
        access(16'h3FFC, 2'd2, 1'b0, "R6 below window");
        expect_reg(2'd1, 32'h1, "R6 pending untouched");
        access(16'h4800, 2'd3, 1'b0, "R5 kind none never denied");

        access(16'h4004, 2'd2, 1'b1, "R5 low fetch denied");
        expect_reg(2'd2, 32'h0002_4004, "R7 fault fetch capture");

        // R9 enable gating
        wr(2'd1, 32'h0);
        chk("R9 irq off when disabled", 32'(irq), 32'h0);
        expect_reg(2'd1, 32'h4, "R9 pending without enable");
        wr(2'd1, 32'h2);
        expect_reg(2'd1, 32'h6, "R8 clear set pending still");
        expect_reg(2'd1, 32'h2, "R8 pending cleared");
        wr(2'd1, 32'h0);

        // R3 / R4 rejection
        wr(2'd0, 32'h3FFC_003F);
        expect_reg(2'd0, 32'h4800_000B, "R3 below base rejected");
        wr(2'd0, 32'h6000_003F);
        expect_reg(2'd0, 32'h4800_000B, "R3 above top rejected");
        wr(2'd0, 32'h4802_003F);
        expect_reg(2'd0, 32'h4800_000B, "R4 unaligned rejected");
        wr(2'd0, 32'h5FFC_0024);
        expect_reg(2'd0, 32'h5FFC_0024, "R3 top boundary accepted");
        access(16'h5FFC, 2'd2, 1'b0, "R5 high fetch allowed");
        access(16'h5FF8, 2'd2, 1'b0, "R5 low fetch allowed");
        access(16'h5FF8, 2'd0, 1'b1, "R5 low read denied");
        access(16'h5FFC, 2'd0, 1'b1, "R5 high read denied");
        expect_reg(2'd2, 32'h0000_5FF8, "R7 read capture");
        wr(2'd1, 32'h1);

        // R10 / R11 lock
        wr(2'd3, 32'h0);
        expect_reg(2'd3, 32'h0, "R10 zero does not lock");
        wr(2'd3, 32'h1);
        expect_reg(2'd3, 32'h1, "R10 lock set");
        wr(2'd0, 32'h4800_003F);
        expect_reg(2'd0, 32'h5FFC_0024, "R11 config frozen");
        wr(2'd1, 32'h0);
        expect_reg(2'd1, 32'h5, "R11 enable frozen");
        wr(2'd1, 32'h3);
        step();
        expect_reg(2'd1, 32'h3, "R11 clear still works");
        wr(2'd1, 32'h1);
        wr(2'd3, 32'h0);
        expect_reg(2'd3, 32'h1, "R10 lock sticky");

        // R10 only reset releases the lock
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
        expect_reg(2'd3, 32'h0, "R10 lock cleared by reset");
        expect_reg(2'd0, 32'h4000_003F, "R1 config after second reset");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule